// File: doc/BRIEF.md
# PHY Management Access Bridge

This block gives software a single 32-bit register through which it can read and write the 16-bit registers of an external Ethernet PHY. A host write to the register starts a serial management frame on a clock/data pin pair. The direction is chosen by the top bit, called the flag. Software then polls the same register until the flag shows that the frame has finished. The flag works in opposite directions for the two operations. A write command is issued with the flag set, and the hardware clears it when the frame is done. A read command is issued with the flag clear, and the hardware sets it once the low half of the register holds the data returned by the PHY.

The management clock is the system clock divided down by a parameter, and it runs only while a frame is being sent. Outgoing bits change while the management clock is low, and the PHY samples them on its rising edge. On reads, the bridge releases the data pin for the two turnaround bit times and for the 16 data bits, and captures each data bit on a rising edge. The bridge serves one fixed PHY address. A host write that arrives while a frame is in flight is dropped.

Top module: `phy_mgmt_bridge`

## Requirements
- R1: After reset the host register reads 0x0000_0000, the management clock is low and the data pin output enable is low.
- R2: The host register reads as {flag at bit 31, zeros at bits 30:21, register address at bits 20:16, data at bits 15:0}.
- R3: A host write with bit 31 = 1 sends, MSB first, 32 ones, start 01, opcode 01, the 5-bit PHY address (parameter, default 1), the 5-bit register address from bits 20:16, turnaround 10, then data bits 15:0. The output enable stays high for all 64 bits.
- R4: During a write frame the flag reads 1. It reads 0 starting with the system clock edge that comes 128*MDC_HALF cycles after the command was accepted.
- R5: A host write with bit 31 = 0 sends the same frame header with opcode 10. The output enable is low for the two turnaround bits and the 16 data bits. The flag reads 0 while busy and becomes 1 at the same completion point as R4, with bits 15:0 holding the 16 bits sampled on the MDC rising edges after turnaround, MSB first.
- R6: Once a command is accepted, the address field shows its address. A write command places its data in bits 15:0 at once. During a read, bits 15:0 keep the previous result until completion.
- R7: A host write while a frame is in progress changes nothing in the register and starts no extra frame.
- R8: MDC is low whenever no frame is in progress. While a frame runs, MDC has a period of 2*MDC_HALF system clocks. The data output never changes on a system clock edge at which MDC rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | One-cycle write strobe for the host register |
| host_wdata | input | 32 | Value written to the host register |
| host_rdata | output | 32 | Current host register value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | High while the bridge drives the data pin |
| mdio_in | input | 1 | Management data returned by the PHY |

## Verification
Write commands are tried with data patterns 0xBEEF, 0x1234, all zeros and all ones at register addresses 0, 3, 5 and 31. Together these patterns separate a correct bit order and field placement from shifted, swapped or stuck bits in each part of the frame. Reads are sent to addresses the PHY model has never written, which return a value derived from the address, and to addresses it has written. This distinguishes genuine capture from a stale register, and the held data during busy from early updates. A second host write is injected in the middle of both a write frame and a read frame, so any path by which a busy write leaks into the register or into a new frame shows up. The flag is sampled one cycle before and on the exact completion cycle, which pins down when completion happens.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

   // frame geometry
   localparam int PRE_LEN    = 32;
   localparam int DATA_W     = 16;
   localparam int REG_AW     = 5;
   localparam int PHY_AW     = 5;
   localparam int FRAME_LEN  = PRE_LEN + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
   localparam int TA_IDX     = FRAME_LEN - DATA_W - 2;
   localparam int DATA_IDX   = FRAME_LEN - DATA_W;
   localparam int LAST_IDX   = FRAME_LEN - 1;
   localparam int IDX_W      = $clog2(FRAME_LEN);

   // host register layout
   localparam int HOST_W     = 32;
   localparam int FLAG_BIT   = 31;
   localparam int ADDR_LSB   = 16;

   typedef enum logic [1:0] {
      OPC_WRITE = 2'b01,
      OPC_READ  = 2'b10
   } mgmt_opc_e;

   function automatic logic [FRAME_LEN-1:0] build_frame(
      input logic              is_rd,
      input logic [PHY_AW-1:0] phy,
      input logic [REG_AW-1:0] rg,
      input logic [DATA_W-1:0] dat
   );
      mgmt_opc_e opc;
      logic [1:0] ta;
      logic [DATA_W-1:0] body;
      opc  = is_rd ? OPC_READ : OPC_WRITE;
      ta   = is_rd ? 2'b11 : 2'b10;
      body = is_rd ? '0 : dat;
      return {{PRE_LEN{1'b1}}, 2'b01, opc, phy, rg, ta, body};
   endfunction

endpackage

// File: rtl/mgmt_clk_div.sv
module mgmt_clk_div #(
   parameter int HALF_PERIOD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_tick,
   output logic fall_tick
);

   logic tick;
   logic mdc_q;

   if (HALF_PERIOD < 1) begin : g_bad_half
      $error("mgmt_clk_div: HALF_PERIOD must be at least 1");
   end

   generate
      if (HALF_PERIOD == 1) begin : g_div_one
         assign tick = run;
      end else begin : g_div_cnt
         localparam int CW = $clog2(HALF_PERIOD);
         localparam logic [CW-1:0] CNT_MAX = CW'(HALF_PERIOD - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run) begin
               cnt <= '0;
            end else if (cnt == CNT_MAX) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end

         assign tick = run && (cnt == CNT_MAX);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_q <= 1'b0;
      end else if (!run) begin
         mdc_q <= 1'b0;
      end else if (tick) begin
         mdc_q <= ~mdc_q;
      end
   end

   assign mdc       = mdc_q;
   assign rise_tick = tick && !mdc_q;
   assign fall_tick = tick &&  mdc_q;

   AST_MDC_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc); // R8

endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
   import phy_mgmt_pkg::*;
#(
   parameter int PHY_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_rd,
   input  logic [REG_AW-1:0] start_reg,
   input  logic [DATA_W-1:0] start_data,
   input  logic              rise_tick,
   input  logic              fall_tick,
   input  logic              mdio_in,
   output logic              busy,
   output logic              done,
   output logic              done_rd,
   output logic [DATA_W-1:0] rd_data,
   output logic              mdio_out,
   output logic              mdio_oe
);

   localparam logic [PHY_AW-1:0] PHY_FIELD = PHY_AW'(PHY_ADDR);
   localparam logic [IDX_W-1:0]  IDX_TA    = IDX_W'(TA_IDX);
   localparam logic [IDX_W-1:0]  IDX_DATA  = IDX_W'(DATA_IDX);
   localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(LAST_IDX);

   if (PHY_ADDR < 0 || PHY_ADDR >= (1 << PHY_AW)) begin : g_bad_phy
      $error("mgmt_frame_seq: PHY_ADDR does not fit the address field");
   end

   logic                 busy_q;
   logic                 rd_q;
   logic [IDX_W-1:0]     bit_idx;
   logic [FRAME_LEN-1:0] shreg;
   logic [DATA_W-1:0]    cap;
   logic                 in_release;

   assign in_release = rd_q && (bit_idx >= IDX_TA);
   assign done       = busy_q && fall_tick && (bit_idx == IDX_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         rd_q    <= 1'b0;
         bit_idx <= '0;
         shreg   <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q  <= 1'b1;
            rd_q    <= start_rd;
            bit_idx <= '0;
            shreg   <= build_frame(start_rd, PHY_FIELD, start_reg, start_data);
         end
      end else if (fall_tick) begin
         if (bit_idx == IDX_LAST) begin
            busy_q <= 1'b0;
         end else begin
            bit_idx <= bit_idx + 1'b1;
            shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap <= '0;
      end else if (busy_q && rd_q && rise_tick && (bit_idx >= IDX_DATA)) begin
         cap <= {cap[DATA_W-2:0], mdio_in};
      end
   end

   assign busy     = busy_q;
   assign done_rd  = rd_q;
   assign rd_data  = cap;
   assign mdio_out = busy_q && shreg[FRAME_LEN-1];
   assign mdio_oe  = busy_q && !in_release;

   AST_TA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && rd_q && bit_idx >= IDX_TA) |-> !mdio_oe); // R5

   AST_IDLE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !mdio_oe); // R1

endmodule

// File: rtl/phy_mgmt_bridge.sv
module phy_mgmt_bridge
   import phy_mgmt_pkg::*;
#(
   parameter int MDC_HALF = 4,
   parameter int PHY_ADDR = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_wr,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata,
   output logic        mdc,
   output logic        mdio_out,
   output logic        mdio_oe,
   input  logic        mdio_in
);

   if (HOST_W != 32 || ADDR_LSB + REG_AW > FLAG_BIT) begin : g_bad_layout
      $error("phy_mgmt_bridge: host register layout is inconsistent");
   end

   logic              flag_q;
   logic [REG_AW-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   logic              accept;
   logic              seq_busy;
   logic              seq_done;
   logic              seq_done_rd;
   logic [DATA_W-1:0] seq_rd_data;
   logic              rise_tick;
   logic              fall_tick;
   logic              cmd_is_wr;
   logic              unused_wdata;

   assign cmd_is_wr    = host_wdata[FLAG_BIT];
   assign accept       = host_wr && !seq_busy;
   assign unused_wdata = ^host_wdata[FLAG_BIT-1:ADDR_LSB+REG_AW];

   mgmt_clk_div #(
      .HALF_PERIOD (MDC_HALF)
   ) u_clk_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (seq_busy),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mgmt_frame_seq #(
      .PHY_ADDR (PHY_ADDR)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .start_rd   (!cmd_is_wr),
      .start_reg  (host_wdata[ADDR_LSB +: REG_AW]),
      .start_data (host_wdata[DATA_W-1:0]),
      .rise_tick  (rise_tick),
      .fall_tick  (fall_tick),
      .mdio_in    (mdio_in),
      .busy       (seq_busy),
      .done       (seq_done),
      .done_rd    (seq_done_rd),
      .rd_data    (seq_rd_data),
      .mdio_out   (mdio_out),
      .mdio_oe    (mdio_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (accept) begin
         flag_q <= cmd_is_wr;
         addr_q <= host_wdata[ADDR_LSB +: REG_AW];
         if (cmd_is_wr) begin
            data_q <= host_wdata[DATA_W-1:0];
         end
      end else if (seq_done) begin
         flag_q <= seq_done_rd;
         if (seq_done_rd) begin
            data_q <= seq_rd_data;
         end
      end
   end

   always_comb begin
      host_rdata                          = '0;
      host_rdata[FLAG_BIT]                = flag_q;
      host_rdata[ADDR_LSB +: REG_AW]      = addr_q;
      host_rdata[DATA_W-1:0]              = data_q;
   end

   AST_WR_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && !seq_done_rd) |-> flag_q); // R4

   AST_RD_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && seq_done_rd) |-> !flag_q); // R5

   AST_BUSY_HOLDS_REG: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && !seq_done) |=> $stable(host_rdata)); // R7

   AST_BUSY_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && host_wr) |=> $stable(addr_q)); // R6

   AST_MDIO_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> $stable(mdio_out)); // R8

endmodule

// File: tb/phy_mgmt_bridge_tb.sv
module phy_mgmt_bridge_tb;

   localparam int H         = 2;
   localparam int FRAME_CYC = 128 * H;

   typedef struct {
      bit        rd;
      bit [4:0]  rg;
      bit [15:0] dat;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        host_wr;
   logic [31:0] host_wdata;
   logic [31:0] host_rdata;
   logic        mdc;
   logic        mdio_out;
   logic        mdio_oe;
   logic        mdio_in = 1'b1;

   int n_chk = 0;
   int n_bad = 0;
   int m_chk = 0;
   int m_bad = 0;
   int frames = 0;
   int rise_n = 0;
   int cyc = 0;
   bit finished = 1'b0;

   exp_t        exp_q[$];
   exp_t        mon_e;
   logic [63:0] seen;
   logic [63:0] oe_seen;
   logic [63:0] want;
   logic [15:0] phy_mem [32];
   logic [31:0] wr_mask = '0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc++;

   phy_mgmt_bridge #(
      .MDC_HALF (H),
      .PHY_ADDR (1)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .mdc        (mdc),
      .mdio_out   (mdio_out),
      .mdio_oe    (mdio_oe),
      .mdio_in    (mdio_in)
   );

   function automatic logic [15:0] dflt(input logic [4:0] r);
      return {r, 3'b101, r, 3'b011};
   endfunction

   function automatic logic [31:0] regv(input bit f, input logic [4:0] r, input logic [15:0] d);
      return {f, 10'b0, r, d};
   endfunction

   // PHY model and frame monitor: pops the expected item and compares the frame
   always @(posedge mdc) begin
      seen[63-rise_n]    = mdio_out;
      oe_seen[63-rise_n] = mdio_oe;
      rise_n++;
      if (rise_n == 64) begin
         rise_n = 0;
         frames++;
         m_chk++;
         if (exp_q.size() == 0) begin
            m_bad++;
            $display("FAIL R7: unexpected frame act=%h exp=none", seen);
         end else begin
            mon_e = exp_q.pop_front();
            if (mon_e.rd) begin
               want = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd1, mon_e.rg, 18'h0};
               if (seen[63:18] != want[63:18] ||
                   oe_seen != {{46{1'b1}}, 18'h0}) begin
                  m_bad++;
                  $display("FAIL R5: read frame act=%h oe=%h exp=%h", seen, oe_seen, want);
               end
            end else begin
               want = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd1, mon_e.rg, 2'b10, mon_e.dat};
               if (seen != want || oe_seen != {64{1'b1}}) begin
                  m_bad++;
                  $display("FAIL R3: write frame act=%h oe=%h exp=%h", seen, oe_seen, want);
               end else begin
                  phy_mem[mon_e.rg] = mon_e.dat;
                  wr_mask[mon_e.rg] = 1'b1;
               end
            end
         end
      end
   end

   // PHY answers a read: bit n of the frame driven while MDC is low
   always @(negedge mdc) begin
      if (rise_n >= 48 && rise_n <= 63 && seen[29:28] == 2'b10) begin
         if (wr_mask[seen[22:18]])
            mdio_in = phy_mem[seen[22:18]][63-rise_n];
         else
            mdio_in = dflt(seen[22:18])[63-rise_n];
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   // driver: issue a command, push the expected frame; ends half a cycle after acceptance
   task automatic issue(input bit rd, input logic [4:0] rg, input logic [15:0] dat);
      exp_t e;
      @(negedge clk);
      host_wr    = 1'b1;
      host_wdata = regv(!rd, rg, dat);
      e.rd = rd; e.rg = rg; e.dat = dat;
      exp_q.push_back(e);
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic wait_end(input logic [31:0] busy_v, input logic [31:0] final_v,
                           input int poke_at, input logic [31:0] poke_v, input string req);
      chk(host_rdata == busy_v, "R6", host_rdata, busy_v);
      for (int c = 1; c < FRAME_CYC; c++) begin
         @(negedge clk);
         if (c == poke_at) begin
            host_wr    = 1'b1;
            host_wdata = poke_v;
         end else begin
            host_wr = 1'b0;
         end
         if (poke_at > 0 && c == poke_at + 1)
            chk(host_rdata == busy_v, "R7", host_rdata, busy_v);
      end
      chk(host_rdata == busy_v, req, host_rdata, busy_v);
      @(negedge clk);
      chk(host_rdata == final_v, req, host_rdata, final_v);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + m_chk, n_bad + m_bad);
   endtask

   initial begin
      int f0;
      int t0;
      rst_n      = 1'b0;
      host_wr    = 1'b0;
      host_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(host_rdata == 32'h0, "R1", host_rdata, 32'h0);
      chk({mdc, mdio_oe} == 2'b00, "R1", {30'h0, mdc, mdio_oe}, 32'h0);

      // R2 R3 R4: write 0xBEEF to register 5
      issue(0, 5'd5, 16'hBEEF);
      chk(host_rdata == 32'h8005_BEEF, "R2", host_rdata, 32'h8005_BEEF);
      wait_end(regv(1, 5'd5, 16'hBEEF), regv(0, 5'd5, 16'hBEEF), -1, 0, "R4");

      // R5 R6: read of unwritten register 31, data held during busy
      issue(1, 5'd31, 16'h0);
      wait_end(regv(0, 5'd31, 16'hBEEF), regv(1, 5'd31, dflt(5'd31)), -1, 0, "R5");

      // R5: read back the value written earlier
      issue(1, 5'd5, 16'h0);
      wait_end(regv(0, 5'd5, dflt(5'd31)), regv(1, 5'd5, 16'hBEEF), -1, 0, "R5");

      // R7: write while a write frame is in flight
      f0 = frames;
      issue(0, 5'd3, 16'h1234);
      wait_end(regv(1, 5'd3, 16'h1234), regv(0, 5'd3, 16'h1234), 40, regv(1, 5'd9, 16'hFFFF), "R7");
      repeat (4) @(negedge clk);
      chk(frames == f0 + 1, "R7", frames, f0 + 1);
      chk(exp_q.size() == 0, "R7", exp_q.size(), 0);

      // R7: read command poked while a read frame is in flight
      issue(1, 5'd0, 16'h0);
      wait_end(regv(0, 5'd0, 16'h1234), regv(1, 5'd0, dflt(5'd0)), 100, regv(0, 5'd7, 16'h0), "R7");

      // R3 boundary patterns, then read back all ones
      issue(0, 5'd0, 16'h0000);
      wait_end(regv(1, 5'd0, 16'h0000), regv(0, 5'd0, 16'h0000), -1, 0, "R3");
      issue(0, 5'd31, 16'hFFFF);
      wait_end(regv(1, 5'd31, 16'hFFFF), regv(0, 5'd31, 16'hFFFF), -1, 0, "R3");
      issue(1, 5'd31, 16'h0);
      wait_end(regv(0, 5'd31, 16'hFFFF), regv(1, 5'd31, 16'hFFFF), -1, 0, "R5");
      issue(1, 5'd0, 16'h0);
      wait_end(regv(0, 5'd0, 16'hFFFF), regv(1, 5'd0, 16'h0000), -1, 0, "R5");

      // R8: MDC period while running, parked low when idle
      issue(0, 5'd12, 16'h5A5A);
      @(posedge mdc);
      t0 = cyc;
      @(posedge mdc);
      chk(cyc - t0 == 2 * H, "R8", cyc - t0, 2 * H);
      repeat (FRAME_CYC) @(negedge clk);
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R8", {30'h0, mdc, mdio_oe}, 32'h0);
      chk(host_rdata == regv(0, 5'd12, 16'h5A5A), "R4", host_rdata, regv(0, 5'd12, 16'h5A5A));
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R3", exp_q.size(), 0);

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         $display("FAIL watchdog: act=hung exp=done");
         n_chk = n_chk + 1;
         n_bad = n_bad + 1;
         summary();
         $finish;
      end
   end

endmodule